// File: doc/BRIEF.md
# Block Memory Copy Engine

This block moves a run of bytes from one region of a byte-wide memory to another, one byte per iteration. A host loads a source pointer, a destination pointer, a byte count and the current flag byte, then pulses `start`. Each iteration has two phases. The engine reads the byte at the source pointer. It then writes that byte to the destination pointer. After the write it steps both pointers by one, up or down, and decrements the count.

There are two forms. In single mode the engine stops after one iteration. In repeat mode it keeps going until the decremented count reaches zero. A starting count of zero wraps, so the engine copies a full 64 KiB. The flag byte is rewritten after every iteration:
- the subtract and half-carry bits are cleared;
- the parity/overflow bit reports whether any count remains.

The updated pointers, count and flags stay on the outputs after completion, so a host can chain operations.

Top module: `bcopy_top`

## Requirements
- R1: While reset is applied and after its release, `busy`, `done`, `memRe` and `memWe` are all low.
- R2: A `start` pulse seen while idle loads the source, destination, count, flag, direction and mode inputs, and `busy` is high from the next cycle on.
- R3: In the read phase `memRe` is high, `memWe` is low and `memAddr` equals the source pointer. This holds until `memReady` is sampled high, and the count does not change while the phase waits.
- R4: In the write phase `memWe` is high and `memAddr` equals the destination pointer. `memWrData` carries the byte read in this iteration. All of this holds until `memReady` is sampled high.
- R5: When a write completes, both pointers move by +1 if `dirDown` was 0 at start, or by -1 if it was 1, wrapping modulo 2^16.
- R6: Every completed write decrements the count by one. A starting count of 0 becomes 0xFFFF, and in repeat mode it gives 65536 iterations.
- R7: After each iteration, flag bit 1 (subtract) and bit 4 (half-carry) are 0. Flag bit 2 (parity/overflow) is 1 when the new count is nonzero and 0 when it is zero. All other flag bits keep the value loaded at start.
- R8: With `repeatMode` = 1 at start, another iteration begins whenever the new count is nonzero. With `repeatMode` = 0, exactly one iteration runs.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the last completed write, and `busy` is low in it.
- R10: A `start` pulse while `busy` is high has no effect on the pointers, count, flags or memory traffic of the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (honoured only when idle) |
| dirDown | input | 1 | 0 = pointers step up, 1 = pointers step down |
| repeatMode | input | 1 | 0 = single iteration, 1 = repeat until count is zero |
| srcInit | input | 16 | Initial source pointer |
| dstInit | input | 16 | Initial destination pointer |
| cntInit | input | 16 | Initial byte count |
| flagsIn | input | 8 | Flag byte at start |
| memAddr | output | 16 | Memory address |
| memRdData | input | 8 | Read data, valid in the cycle `memReady` is high during a read |
| memWrData | output | 8 | Write data |
| memRe | output | 1 | Read request |
| memWe | output | 1 | Write request |
| memReady | input | 1 | Memory accepts the current request at this clock edge |
| srcPtr | output | 16 | Current source pointer |
| dstPtr | output | 16 | Current destination pointer |
| count | output | 16 | Current count |
| flagsOut | output | 8 | Current flag byte |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
`busy` and the read request rise one edge after the start edge. Each phase advances on the first edge at which `memReady` is high. Pointers, count and flags update on the edge that accepts the write, and `done` rises on that same edge. So the bench waits for `done` at falling edges and samples the final state in that cycle, with no fixed delay.

For the stall scenario the bench owns `memReady` and samples the request signals at falling edges. It checks that the address, data and count hold while ready stays low, and that the phase moves only after an edge with ready high. Throttled runs apply the same end-of-operation sampling, so the results do not depend on how many wait cycles occur.

// File: rtl/bcopy_pkg.sv
package bcopy_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_READ  = 2'd1,
    PH_WRITE = 2'd2
  } phase_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture start operands
    logic grab;   // capture read byte
    logic step;   // advance pointers, count and flags
  } dpCtl_t;

endpackage

// File: rtl/bcopy_dp.sv
module bcopy_dp
  import bcopy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int N_BIT  = 1,
  parameter int PV_BIT = 2,
  parameter int H_BIT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic              dirDown,
  input  logic [ADDR_W-1:0] srcInit,
  input  logic [ADDR_W-1:0] dstInit,
  input  logic [ADDR_W-1:0] cntInit,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [ADDR_W-1:0] count,
  output logic [FLAG_W-1:0] flagsOut,
  output logic [DATA_W-1:0] dataHold,
  output logic              lastIter
);

  localparam logic [FLAG_W-1:0] PV_MASK  = FLAG_W'(1) << PV_BIT;
  localparam logic [FLAG_W-1:0] CLR_MASK = (FLAG_W'(1) << N_BIT) |
                                           (FLAG_W'(1) << H_BIT) | PV_MASK;

  logic              dirQ;
  logic [ADDR_W-1:0] stepVal;
  logic [ADDR_W-1:0] cntNext;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    stepVal   = dirQ ? {ADDR_W{1'b1}} : ADDR_W'(1);
    cntNext   = count - ADDR_W'(1);
    lastIter  = (cntNext == '0);
    flagsNext = (flagsOut & ~CLR_MASK) | (lastIter ? '0 : PV_MASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr   <= '0;
      dstPtr   <= '0;
      count    <= '0;
      flagsOut <= '0;
      dataHold <= '0;
      dirQ     <= 1'b0;
    end else begin
      if (ctl.load) begin
        srcPtr   <= srcInit;
        dstPtr   <= dstInit;
        count    <= cntInit;
        flagsOut <= flagsIn;
        dirQ     <= dirDown;
      end
      if (ctl.grab) begin
        dataHold <= memRdData;
      end
      if (ctl.step) begin
        srcPtr   <= srcPtr + stepVal;
        dstPtr   <= dstPtr + stepVal;
        count    <= cntNext;
        flagsOut <= flagsNext;
      end
    end
  end

endmodule

// File: rtl/bcopy_ctrl.sv
module bcopy_ctrl
  import bcopy_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   start,
  input  logic   repeatMode,
  input  logic   memReady,
  input  logic   lastIter,
  output dpCtl_t ctl,
  output logic   memRe,
  output logic   memWe,
  output logic   busy,
  output logic   done
);

  phase_t phase, phaseNext;
  logic   repQ;
  logic   doneNext;

  always_comb begin
    phaseNext = phase;
    ctl       = '0;
    memRe     = 1'b0;
    memWe     = 1'b0;
    doneNext  = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          ctl.load  = 1'b1;
          phaseNext = PH_READ;
        end
      end
      PH_READ: begin
        memRe = 1'b1;
        if (memReady) begin
          ctl.grab  = 1'b1;
          phaseNext = PH_WRITE;
        end
      end
      PH_WRITE: begin
        memWe = 1'b1;
        if (memReady) begin
          ctl.step = 1'b1;
          if (repQ && !lastIter) begin
            phaseNext = PH_READ;
          end else begin
            phaseNext = PH_IDLE;
            doneNext  = 1'b1;
          end
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      repQ  <= 1'b0;
      done  <= 1'b0;
    end else begin
      phase <= phaseNext;
      done  <= doneNext;
      if (ctl.load) repQ <= repeatMode;
    end
  end

  assign busy = (phase != PH_IDLE);

endmodule

// File: rtl/bcopy_top.sv
module bcopy_top
  import bcopy_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int N_BIT  = 1,
  parameter int PV_BIT = 2,
  parameter int H_BIT  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              dirDown,
  input  logic              repeatMode,
  input  logic [ADDR_W-1:0] srcInit,
  input  logic [ADDR_W-1:0] dstInit,
  input  logic [ADDR_W-1:0] cntInit,
  input  logic [FLAG_W-1:0] flagsIn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [DATA_W-1:0] memRdData,
  output logic [DATA_W-1:0] memWrData,
  output logic              memRe,
  output logic              memWe,
  input  logic              memReady,
  output logic [ADDR_W-1:0] srcPtr,
  output logic [ADDR_W-1:0] dstPtr,
  output logic [ADDR_W-1:0] count,
  output logic [FLAG_W-1:0] flagsOut,
  output logic              busy,
  output logic              done
);

  dpCtl_t ctl;
  logic   lastIter;

  bcopy_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .repeatMode (repeatMode),
    .memReady   (memReady),
    .lastIter   (lastIter),
    .ctl        (ctl),
    .memRe      (memRe),
    .memWe      (memWe),
    .busy       (busy),
    .done       (done)
  );

  bcopy_dp #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FLAG_W (FLAG_W),
    .N_BIT  (N_BIT),
    .PV_BIT (PV_BIT),
    .H_BIT  (H_BIT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .dirDown   (dirDown),
    .srcInit   (srcInit),
    .dstInit   (dstInit),
    .cntInit   (cntInit),
    .flagsIn   (flagsIn),
    .memRdData (memRdData),
    .srcPtr    (srcPtr),
    .dstPtr    (dstPtr),
    .count     (count),
    .flagsOut  (flagsOut),
    .dataHold  (memWrData),
    .lastIter  (lastIter)
  );

  assign memAddr = memWe ? dstPtr : srcPtr;

endmodule

// File: rtl/bcopy_chk.sv
module bcopy_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int FLAG_W = 8,
  parameter int N_BIT  = 1,
  parameter int PV_BIT = 2,
  parameter int H_BIT  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWrData,
  input logic              memRe,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] srcPtr,
  input logic [ADDR_W-1:0] count,
  input logic [FLAG_W-1:0] flagsOut,
  input logic              busy,
  input logic              done
);

  logic wrAcc;
  assign wrAcc = memWe && memReady;

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe)); // R3

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && !memReady) |=> (memRe && $stable(memAddr) && $stable(count))); // R3

  AST_WRITE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && !memReady) |=> (memWe && $stable(memAddr) && $stable(memWrData))); // R4

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> (((srcPtr - $past(srcPtr)) == ADDR_W'(1)) ||
               ((srcPtr - $past(srcPtr)) == {ADDR_W{1'b1}}))); // R5

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> (count == ($past(count) - ADDR_W'(1)))); // R6

  AST_FLAG_RULE: assert property (@(posedge clk) disable iff (!rstN)
    wrAcc |=> ((flagsOut[PV_BIT] == (count != '0)) &&
               !flagsOut[N_BIT] && !flagsOut[H_BIT])); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R9

  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !wrAcc) |=> ($stable(srcPtr) && $stable(count) && $stable(flagsOut))); // R10

endmodule

bind bcopy_top bcopy_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .FLAG_W (FLAG_W),
  .N_BIT  (N_BIT),
  .PV_BIT (PV_BIT),
  .H_BIT  (H_BIT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .memAddr   (memAddr),
  .memWrData (memWrData),
  .memRe     (memRe),
  .memWe     (memWe),
  .memReady  (memReady),
  .srcPtr    (srcPtr),
  .count     (count),
  .flagsOut  (flagsOut),
  .busy      (busy),
  .done      (done)
);

// File: tb/sim_bcopy_top.sv
module sim_bcopy_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start, dirDown, repeatMode;
  logic [15:0] srcInit, dstInit, cntInit;
  logic [7:0]  flagsIn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData, memWrData;
  logic        memRe, memWe, memReady;
  logic [15:0] srcPtr, dstPtr, count;
  logic [7:0]  flagsOut;
  logic        busy, done;

  logic [7:0]  mem   [0:65535];
  logic [7:0]  model [0:65535];
  int          nChecks = 0;
  int          nErrors = 0;
  int          readyMode = 0;
  logic        readyVal = 1'b0;
  int          negCnt = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  always @(negedge clk) negCnt <= negCnt + 1;

  assign memReady  = (readyMode == 0) ? 1'b1 :
                     (readyMode == 1) ? readyVal : ((negCnt % 3) == 0);
  assign memRdData = mem[memAddr];

  always @(posedge clk) if (memWe && memReady) mem[memAddr] <= memWrData;

  bcopy_top u0 (
    .clk(clk), .rstN(rstN), .start(start), .dirDown(dirDown),
    .repeatMode(repeatMode), .srcInit(srcInit), .dstInit(dstInit),
    .cntInit(cntInit), .flagsIn(flagsIn), .memAddr(memAddr),
    .memRdData(memRdData), .memWrData(memWrData), .memRe(memRe),
    .memWe(memWe), .memReady(memReady), .srcPtr(srcPtr), .dstPtr(dstPtr),
    .count(count), .flagsOut(flagsOut), .busy(busy), .done(done)
  );

  task automatic checkEq(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic compareMem(input string req);
    int bad = 0;
    for (int i = 0; i < 65536; i++) if (mem[i] !== model[i]) bad++;
    checkEq(req, "memory mismatches", bad, 0);
  endtask

  task automatic modelCopy(input logic [15:0] s, input logic [15:0] d,
                           input logic [15:0] c, input logic [7:0] f,
                           input bit down, input bit rep,
                           output logic [15:0] es, output logic [15:0] ed,
                           output logic [15:0] ec, output logic [7:0] ef);
    logic [15:0] st;
    st = down ? 16'hFFFF : 16'h0001;
    do begin
      model[d] = model[s];
      s = s + st;
      d = d + st;
      c = c - 16'h1;
      f = (f & ~8'h16) | ((c != 16'h0) ? 8'h04 : 8'h00);
    end while (rep && (c != 16'h0));
    es = s; ed = d; ec = c; ef = f;
  endtask

  task automatic pulseStart(input logic [15:0] s, input logic [15:0] d,
                            input logic [15:0] c, input logic [7:0] f,
                            input bit down, input bit rep);
    @(negedge clk);
    srcInit = s; dstInit = d; cntInit = c; flagsIn = f;
    dirDown = down; repeatMode = rep; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic checkFinal(input string req, input logic [15:0] es,
                            input logic [15:0] ed, input logic [15:0] ec,
                            input logic [7:0] ef);
    checkEq(req, "srcPtr", srcPtr, es);
    checkEq(req, "dstPtr", dstPtr, ed);
    checkEq(req, "count", count, ec);
    checkEq(req, "flags", flagsOut, ef);
  endtask

  task automatic runAndCheck(input string req, input logic [15:0] s,
                             input logic [15:0] d, input logic [15:0] c,
                             input logic [7:0] f, input bit down, input bit rep);
    logic [15:0] es, ed, ec;
    logic [7:0]  ef;
    modelCopy(s, d, c, f, down, rep, es, ed, ec, ef);
    pulseStart(s, d, c, f, down, rep);
    waitDone();
    checkFinal(req, es, ed, ec, ef);
  endtask

  task automatic testReset();
    checkEq("R1", "busy after reset", busy, 0);
    checkEq("R1", "done after reset", done, 0);
    checkEq("R1", "requests after reset", {memRe, memWe}, 0);
  endtask

  task automatic testSingleInc();
    logic [15:0] es, ed, ec;
    logic [7:0]  ef;
    modelCopy(16'h1000, 16'h2000, 16'd5, 8'hFF, 0, 0, es, ed, ec, ef);
    pulseStart(16'h1000, 16'h2000, 16'd5, 8'hFF, 0, 0);
    checkEq("R2", "busy after start", busy, 1);
    waitDone();
    checkEq("R9", "busy low with done", busy, 0);
    checkFinal("R8", es, ed, ec, ef);
    checkEq("R7", "flag value", flagsOut, 8'hED);
    checkEq("R4", "copied byte", mem[16'h2000], mem[16'h1000]);
    @(negedge clk);
    checkEq("R9", "done one cycle", done, 0);
    compareMem("R8");
  endtask

  task automatic testRepeatInc();
    runAndCheck("R8", 16'h0100, 16'h0300, 16'd8, 8'h00, 0, 1);
    checkEq("R7", "pv clear at zero", flagsOut[2], 0);
    compareMem("R8");
  endtask

  task automatic testDecWrap();
    runAndCheck("R5", 16'h0002, 16'h0005, 16'd6, 8'h16, 1, 1);
    compareMem("R5");
  endtask

  task automatic testIncWrap();
    runAndCheck("R5", 16'hFFFE, 16'h7FFE, 16'd4, 8'h80, 0, 1);
    compareMem("R5");
  endtask

  task automatic testStall();
    logic [15:0] es, ed, ec;
    logic [7:0]  ef;
    readyMode = 1; readyVal = 1'b0;
    modelCopy(16'h4000, 16'h5000, 16'd2, 8'h41, 0, 0, es, ed, ec, ef);
    pulseStart(16'h4000, 16'h5000, 16'd2, 8'h41, 0, 0);
    repeat (3) @(negedge clk);
    checkEq("R3", "read request held", {memRe, memWe}, 2'b10);
    checkEq("R3", "read address", memAddr, 16'h4000);
    checkEq("R3", "count held while waiting", count, 16'd2);
    readyVal = 1'b1;
    @(negedge clk);
    readyVal = 1'b0;
    checkEq("R4", "write request", {memRe, memWe}, 2'b01);
    checkEq("R4", "write address", memAddr, 16'h5000);
    checkEq("R4", "write data", memWrData, mem[16'h4000]);
    repeat (2) @(negedge clk);
    checkEq("R4", "write held while waiting", {memWe, busy}, 2'b11);
    readyVal = 1'b1;
    waitDone();
    checkFinal("R7", es, ed, ec, ef);
    readyMode = 0;
    compareMem("R4");
  endtask

  task automatic testStartIgnored();
    logic [15:0] es, ed, ec;
    logic [7:0]  ef;
    readyMode = 2;
    modelCopy(16'h6000, 16'h6800, 16'd10, 8'h28, 0, 1, es, ed, ec, ef);
    pulseStart(16'h6000, 16'h6800, 16'd10, 8'h28, 0, 1);
    repeat (3) @(negedge clk);
    checkEq("R10", "busy before second start", busy, 1);
    srcInit = 16'h9000; dstInit = 16'hA000; cntInit = 16'd3;
    flagsIn = 8'hFF; dirDown = 1'b1; repeatMode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone();
    checkFinal("R10", es, ed, ec, ef);
    readyMode = 0;
    compareMem("R10");
  endtask

  task automatic testZeroSingle();
    runAndCheck("R6", 16'h3000, 16'h3100, 16'd0, 8'h00, 0, 0);
    checkEq("R6", "count wrapped", count, 16'hFFFF);
  endtask

  task automatic testFullWrap();
    runAndCheck("R6", 16'h0000, 16'h8000, 16'd0, 8'h01, 0, 1);
    compareMem("R6");
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; dirDown = 1'b0; repeatMode = 1'b0;
    srcInit = '0; dstInit = '0; cntInit = '0; flagsIn = '0;
    for (int i = 0; i < 65536; i++) begin
      mem[i]   = 8'((i * 7 + 3) ^ (i >> 8));
      model[i] = 8'((i * 7 + 3) ^ (i >> 8));
    end
    repeat (4) @(negedge clk);
    checkEq("R1", "busy in reset", busy, 0);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSingleInc();
    testRepeatInc();
    testDecWrap();
    testIncWrap();
    testStall();
    testStartIgnored();
    testZeroSingle();
    testFullWrap();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nErrors, nChecks);
      $finish;
    end
  end

endmodule